// File: doc/BRIEF.md
# Quad SPI Flash Read Responder

This block is the device-side front end of a serial flash that serves four-bit-wide read transactions. It watches chip select, the serial clock and four data lines. It decodes a command byte, a 24-bit address and a mode byte, waits out the dummy clocks, and then streams bytes taken from a synchronous memory read port. The byte address steps up by one after each byte. Programming, erasing, status access and all other commands lie outside the block, and it ignores them.

The block keeps a continuous-read flag from one transaction to the next. While the flag is set, the next transaction starts directly with the address, so the host saves the eight command clocks. The flag is set or cleared when chip select rises, based on the upper half of the mode byte. It is also cleared by a chip-select pulse that is aborted before data begins.

All pins are sampled in the system clock domain. The serial clock is oversampled. The block samples input nibbles on serial-clock rising edges and changes output nibbles on falling edges.

Top module: `qspiReadResponder`

## Requirements
- R1: After reset, the output enables and the memory read strobe are low, and continuous-read mode is off: the first transaction must begin with a command byte.
- R2: Outside continuous mode, the first 8 serial clocks after chip select falls shift a command byte in on ioIn[0], MSB first. Command EBh starts a read. The 6 clocks that follow take the 24-bit address, one nibble per clock on ioIn[3:0], with the most significant nibble first.
- R3: Any command byte other than EBh makes the block ignore the rest of the transaction. It issues no memory read and drives no output until chip select rises.
- R4: The mode byte is taken over the 2 clocks after the address, upper nibble first. If that upper nibble is 1010b and the transaction reaches its data phase, the next transaction begins directly with the 6 address clocks.
- R5: If the upper mode nibble is any other value, the next transaction again begins with a command byte.
- R6: After the mode byte come 4 dummy clocks, during which the outputs stay disabled. Each byte is then sent over 2 clocks, high nibble first, with bit 7 on ioOut[3] and bit 4 on ioOut[0]. The nibble changes after each falling edge. All four enables go high after the first data-phase falling edge.
- R7: The block issues exactly one single-cycle memory read per byte. The first read uses the received address and is issued at the start of the dummy phase. Each later read uses the previous address plus one, wrapping from FFFFFFh to 000000h.
- R8: All output enables fall in the same clock cycle that csN rises. No memory read starts while chip select stays high.
- R9: If chip select rises during the mode or dummy clocks, continuous mode is cleared.
- R10: In continuous mode, a chip-select pulse of 8 or fewer clocks that never reaches the data phase clears continuous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| ioIn | input | 4 | Data lines as seen at the pins |
| ioOut | output | 4 | Nibble that the block drives onto the data lines |
| ioOe | output | 4 | Per-line output enable |
| memRdEn | output | 1 | Read strobe to the memory, one cycle per byte |
| memAddr | output | 24 | Byte address of the read |
| memRdData | input | 8 | Read data, valid the cycle after memRdEn |

## Verification
The checker assumes that each high and each low phase of sck lasts at least four system clock cycles. Within that time a memory read and its data land before the next falling edge, and two reads can never fall on adjacent cycles. It also assumes that ioIn is steady around each sck rising edge and that csN does not change within a cycle of an sck edge. The bench meets all of this by holding every sck phase for six system clocks. It changes ioIn only while sck is low, and it moves csN only half a serial period away from any sck edge.

// File: rtl/qspiRdPkg.sv
package qspiRdPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic cmdShift;
    logic addrShift;
    logic readFirst;
    logic driveHigh;
    logic driveLow;
  } strobe_t;

endpackage

// File: rtl/qspiRdCtrl.sv
module qspiRdCtrl
  import qspiRdPkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int ADDR_W     = 24,
  parameter int DUMMY_CLKS = 4,
  parameter logic [CMD_W-1:0] READ_CMD  = 8'hEB,
  parameter logic [3:0]       KEEP_CODE = 4'hA
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckRise,
  input  logic             sckFall,
  input  logic             csFall,
  input  logic             csRise,
  input  logic             csLow,
  input  logic [3:0]       ioS,
  input  logic [CMD_W-1:0] cmdNext,
  output strobe_t          stb,
  output logic             oeOn
);

  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int CNT_W    = $clog2(CMD_W + ADDR_NIB + DUMMY_CLKS + 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             contMode;
  logic             modeKeep;
  logic             half;

  logic riseLive;
  logic fallLive;
  assign riseLive = sckRise & csLow;
  assign fallLive = sckFall & csLow;

  always_comb begin
    stb = '0;
    if (riseLive) begin
      unique case (phase)
        PH_CMD:  stb.cmdShift  = 1'b1;
        PH_ADDR: stb.addrShift = 1'b1;
        PH_MODE: stb.readFirst = (cnt == CNT_W'(1));
        default: ;
      endcase
    end
    if (fallLive && phase == PH_DATA) begin
      stb.driveHigh = ~half;
      stb.driveLow  = half;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      contMode <= 1'b0;
      modeKeep <= 1'b0;
      half     <= 1'b0;
      oeOn     <= 1'b0;
    end else if (csRise) begin
      // only a transaction that reached data keeps the mode decision
      contMode <= (phase == PH_DATA) ? modeKeep : 1'b0;
      phase    <= PH_IDLE;
      half     <= 1'b0;
      oeOn     <= 1'b0;
    end else if (csFall) begin
      phase    <= contMode ? PH_ADDR : PH_CMD;
      cnt      <= '0;
      half     <= 1'b0;
      oeOn     <= 1'b0;
      modeKeep <= 1'b0;
    end else if (riseLive) begin
      unique case (phase)
        PH_CMD: begin
          if (cnt == CNT_W'(CMD_W - 1)) begin
            cnt   <= '0;
            phase <= (cmdNext == READ_CMD) ? PH_ADDR : PH_SKIP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt == CNT_W'(ADDR_NIB - 1)) begin
            cnt   <= '0;
            phase <= PH_MODE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_MODE: begin
          if (cnt == '0) begin
            modeKeep <= (ioS == KEEP_CODE);
            cnt      <= cnt + 1'b1;
          end else begin
            cnt   <= '0;
            phase <= PH_DUMMY;
          end
        end
        PH_DUMMY: begin
          if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (fallLive && phase == PH_DATA) begin
      half <= ~half;
      oeOn <= 1'b1;
    end
  end

endmodule

// File: rtl/qspiRdData.sv
module qspiRdData
  import qspiRdPkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [3:0]        ioS,
  input  logic [7:0]        memRdData,
  output logic [CMD_W-1:0]  cmdNext,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        nibOut
);

  logic [CMD_W-1:0]  cmdReg;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] addrInc;
  logic              rdPend;
  logic [7:0]        byteReg;

  assign cmdNext = {cmdReg[CMD_W-2:0], ioS[0]};
  assign addrInc = addrReg + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      addrReg <= '0;
      memRdEn <= 1'b0;
      memAddr <= '0;
      rdPend  <= 1'b0;
      byteReg <= '0;
      nibOut  <= '0;
    end else begin
      if (stb.cmdShift)  cmdReg  <= cmdNext;
      if (stb.addrShift) addrReg <= {addrReg[ADDR_W-5:0], ioS};

      memRdEn <= stb.readFirst | stb.driveLow;
      if (stb.readFirst) memAddr <= addrReg;
      if (stb.driveLow) begin
        memAddr <= addrInc;
        addrReg <= addrInc;
      end

      rdPend <= memRdEn;
      if (rdPend) byteReg <= memRdData;

      if (stb.driveHigh) nibOut <= byteReg[7:4];
      if (stb.driveLow)  nibOut <= byteReg[3:0];
    end
  end

endmodule

// File: rtl/qspiReadResponder.sv
module qspiReadResponder
  import qspiRdPkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int ADDR_W     = 24,
  parameter int DUMMY_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData
);

  logic       csD, csQ, sckD, sckQ;
  logic [3:0] ioD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csD  <= 1'b1;
      csQ  <= 1'b1;
      sckD <= 1'b0;
      sckQ <= 1'b0;
      ioD  <= '0;
    end else begin
      csD  <= csN;
      csQ  <= csD;
      sckD <= sck;
      sckQ <= sckD;
      ioD  <= ioIn;
    end
  end

  logic sckRise, sckFall, csFall, csRise;
  assign sckRise = sckD & ~sckQ;
  assign sckFall = ~sckD & sckQ;
  assign csFall  = ~csD & csQ;
  assign csRise  = csD & ~csQ;

  strobe_t          stb;
  logic [CMD_W-1:0] cmdNext;
  logic             oeOn;

  qspiRdCtrl #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DUMMY_CLKS(DUMMY_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csFall(csFall), .csRise(csRise), .csLow(~csD), .ioS(ioD),
    .cmdNext(cmdNext), .stb(stb), .oeOn(oeOn)
  );

  qspiRdData #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .ioS(ioD), .memRdData(memRdData),
    .cmdNext(cmdNext), .memRdEn(memRdEn), .memAddr(memAddr), .nibOut(ioOut)
  );

  // release each lane straight from the pin so the bus frees at once
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign ioOe[g] = oeOn & ~csN;
  end

endmodule

// File: rtl/qspiReadResponderChk.sv
module qspiReadResponderChk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic [3:0]        ioOe,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr
);

  logic [ADDR_W-1:0] lastAddr;
  logic [1:0]        readsSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      readsSel <= '0;
    end else begin
      if (memRdEn) lastAddr <= memAddr;
      if (csN) readsSel <= '0;
      else if (memRdEn && readsSel != 2'd3) readsSel <= readsSel + 1'b1;
    end
  end

  // R7: streaming reads step the address by one, with wrap
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && ioOe != 4'h0) |-> memAddr == ADDR_W'(lastAddr + 1'b1));

  // R7: a read strobe lasts a single cycle
  a_r7_read_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R6: outputs are enabled only once a read was issued in this selection
  a_r6_oe_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe != 4'h0) |-> readsSel != 2'd0);

  // R8: no read begins while deselected
  a_r8_quiet_deselect: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !memRdEn);

endmodule

bind qspiReadResponder qspiReadResponderChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .ioOe(ioOe),
  .memRdEn(memRdEn), .memAddr(memAddr)
);

// File: tb/qspiReadResponder_tb.sv
module qspiReadResponder_tb;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sck = 1'b0;
  logic [3:0]  ioIn = '0;
  logic [3:0]  ioOut, ioOe;
  logic        memRdEn;
  logic [23:0] memAddr;
  logic [7:0]  memRdData;

  int nCmp = 0;
  int nBad = 0;
  int rdCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qspiReadResponder u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData)
  );

  function automatic logic [7:0] memVal(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) begin
    if (memRdEn) memRdData <= memVal(memAddr);
    if (rstN && memRdEn) rdCount <= rdCount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] expQ[$];
  logic [7:0] obsByte;
  string      obsTag;
  event       byteEv;

  always @(byteEv) begin
    logic [7:0] e;
    if (expQ.size() == 0) begin
      check(1'b0, {obsTag, " unexpected byte"}, obsByte, 0);
    end else begin
      e = expQ.pop_front();
      check(obsByte == e, obsTag, obsByte, e);
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sckCycle(input logic [3:0] v, output logic [3:0] rd, output logic [3:0] oe);
    ioIn = v;
    waitClk(HALF);
    rd = ioOut;
    oe = ioOe;
    sck = 1'b1;
    waitClk(HALF);
    sck = 1'b0;
  endtask

  task automatic csDown();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csUp(input string tag);
    waitClk(HALF);
    csN = 1'b1;
    #1;
    check(ioOe == 4'h0, {"R8 oe release ", tag}, ioOe, 0);
    waitClk(2 * HALF);
  endtask

  task automatic sendHead(input bit useCmd, input logic [7:0] cmd, input logic [23:0] addr);
    logic [3:0] rd, oe;
    if (useCmd)
      for (int i = 7; i >= 0; i--) sckCycle({3'b000, cmd[i]}, rd, oe);
    for (int n = 5; n >= 0; n--) sckCycle(addr[n*4 +: 4], rd, oe);
  endtask

  task automatic readTxn(input bit useCmd, input logic [23:0] addr,
                         input logic [7:0] mode, input int nBytes, input string tag);
    logic [3:0]  rd, oe, hi;
    logic [23:0] a;
    csDown();
    sendHead(useCmd, 8'hEB, addr);
    sckCycle(mode[7:4], rd, oe);
    sckCycle(mode[3:0], rd, oe);
    for (int d = 0; d < 4; d++) begin
      sckCycle(4'h0, rd, oe);
      check(oe == 4'h0, {"R6 dummy quiet ", tag}, oe, 0);
    end
    a = addr;
    for (int b = 0; b < nBytes; b++) begin
      expQ.push_back(memVal(a));
      sckCycle(4'h0, hi, oe);
      check(oe == 4'hF, {"R6 oe in data ", tag}, oe, 4'hF);
      sckCycle(4'h0, rd, oe);
      obsByte = {hi, rd};
      obsTag  = {"R2 R6 R7 data ", tag};
      ->byteEv;
      a = a + 1'b1;
    end
    csUp(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [3:0] rd, oe;
    int c0;
    waitClk(4);
    check(ioOe == 4'h0, "R1 reset oe", ioOe, 0);
    check(memRdEn == 1'b0, "R1 reset read strobe", memRdEn, 0);
    rstN = 1'b1;
    waitClk(4);

    // R1 R2: first transaction needs the command, mode 00h leaves continuous off
    readTxn(1, 24'h123456, 8'h00, 4, "t1");
    // R5: command needed again after a non-keep mode
    readTxn(1, 24'hABCDEF, 8'hA5, 2, "t2 R5");
    // R4 R7: address-only transaction across the top of the address space
    readTxn(0, 24'hFFFFFE, 8'hA0, 4, "t3 R4 wrap");
    // R4: still continuous, another address-only transaction, then leave
    readTxn(0, 24'h000100, 8'h30, 2, "t4 R4");
    readTxn(1, 24'h0F0F0F, 8'hA0, 1, "t5");

    // R10: short invalid pulse while continuous
    csDown();
    for (int i = 0; i < 8; i++) begin
      sckCycle(4'hF, rd, oe);
      check(oe == 4'h0, "R10 pulse quiet", oe, 0);
    end
    csUp("R10");
    readTxn(1, 24'h00ABCD, 8'h00, 2, "t6 R10 after exit");

    // R3: unknown command is ignored
    c0 = rdCount;
    csDown();
    for (int i = 7; i >= 0; i--) sckCycle({3'b000, 8'h9F >> i}, rd, oe);
    for (int i = 0; i < 16; i++) begin
      sckCycle(4'h0, rd, oe);
      check(oe == 4'h0, "R3 no drive after unknown command", oe, 0);
    end
    csUp("R3");
    check(rdCount == c0, "R3 no memory read", rdCount, c0);
    readTxn(1, 24'h445566, 8'h00, 1, "t7 R3 after");

    // R9: abort during dummy while continuous
    readTxn(1, 24'h200000, 8'hA0, 1, "t8");
    csDown();
    sendHead(0, 8'h00, 24'h300000);
    sckCycle(4'hA, rd, oe);
    sckCycle(4'h0, rd, oe);
    sckCycle(4'h0, rd, oe);
    sckCycle(4'h0, rd, oe);
    csUp("R9 dummy");
    readTxn(1, 24'h777777, 8'h00, 2, "t9 R9 dummy abort");

    // R9: abort in the middle of the mode byte
    readTxn(1, 24'h500000, 8'hA0, 1, "t10");
    csDown();
    sendHead(0, 8'h00, 24'h600000);
    sckCycle(4'hA, rd, oe);
    csUp("R9 mode");
    readTxn(1, 24'h135790, 8'h00, 2, "t11 R9 mode abort");

    waitClk(4);
    check(expQ.size() == 0, "R6 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule